// File: doc/BRIEF.md
# Two-Identifier I2C Register Slave

This block is an I2C target that answers on two fixed 7-bit device identifiers. One identifier opens a 48-byte control/status register file. The other opens a user memory of the same depth. Both storage arrays sit inside the block and are cleared at reset. The bus lines are sampled by the system clock through two-flop synchronizers. The block finds START, repeated START and STOP from the sampled lines. It takes an identification byte and an optional single word-address byte. It then performs byte writes, current-address reads and random reads through one auto-incrementing pointer that both spaces share.

The pointer is 00h after reset. It advances by one for each byte stored or sent. It wraps from 2Fh back to 00h, both in sequential reads and in multi-byte writes. A master NACK on read data, or a STOP, sends the block back to idle. The pointer keeps its value, so a later current-address read continues from it. SDA is only ever pulled low, through an output enable, and the enable changes only while SCL is low.

Top module: `i2c_dual_slave`

## Requirements
- R1: An identification byte whose upper seven bits are 1101111 selects the register space. One whose upper seven bits are 1010111 selects the user memory. Either one is ACKed. Any other identifier is NACKed, and the block ignores the bus (no ACK, no store) until the next START.
- R2: Bit 0 of the identification byte sets the direction: 1 reads and 0 writes.
- R3: In a write, the word-address byte and every data byte are ACKed. Each data byte is stored at the pointer in the selected space, and the pointer then advances by one.
- R4: After reset the pointer is 00h, so a current-address read (identification byte with bit 0 = 1 and no address byte) starts at location 00h.
- R5: A random read is a write identification byte, an address byte, a repeated START and a read identification byte. It returns data starting at that address.
- R6: Read data goes out MSB first. The block keeps sending bytes while the master ACKs in the ninth clock, and the pointer advances by one per byte sent. A master NACK ends the transfer, and the pointer is kept for the next current-address read.
- R7: The pointer never exceeds 2Fh. One advance from 2Fh gives 00h, in reads and in writes.
- R8: A word-address byte above 2Fh sets the pointer to 00h.
- R9: SDA is only pulled low (sda_oe = 1). sda_oe changes only while the synchronized SCL is low, and it is 0 in reset and while idle.
- R10: Both storage arrays read 00h after reset.
- R11: A STOP returns the block to idle at any point. An address byte already taken stays in the pointer.
- R12: Both identifiers share one pointer. The pointer left behind by an access to one space is where a current-address read of the other space starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The checker watches the electrical rules on every cycle: sda_oe changes only in the cycle after SCL was seen low, and it stays released while idle and right after a START. It also keeps the pointer inside 00h..2Fh, checks that each advance adds exactly one, and checks that an advance from 2Fh lands on 00h. Only the bench's bus transactions can show that data arrive at the right location in the right space. Those transactions also cover identifier decode and NACK of a foreign identifier, the shared pointer carried across transfers and across spaces, the clamp of an out-of-range address, and the effect of an early STOP.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_MACK
  } ctl_st_t;

  typedef enum logic [1:0] {
    K_ID,
    K_ADDR,
    K_DATA
  } byte_kind_t;

  localparam int NUM_SPACES = 2;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  // bus idles high, so both stages reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges while SCL stays high mark START / STOP
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
  parameter int DEPTH = 48,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave
  import i2c_dual_pkg::*;
#(
  parameter logic [6:0] REG_ID = 7'h6F,
  parameter logic [6:0] USR_ID = 7'h57,
  parameter int         DEPTH  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  ctl_st_t    st;
  byte_kind_t kind;
  logic [2:0] cnt;
  logic       full;
  logic [7:0] sh;
  logic [7:0] tx;
  logic [AW-1:0] ptr;
  logic       sel;
  logic       rw;
  logic       m_ack;

  logic [7:0] rd [NUM_SPACES];
  logic [7:0] rdata;
  logic [AW-1:0] ptr_nxt;
  logic       id_hit, id_usr;
  logic       wr_en, tx_load, ptr_step;

  i2c_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2c_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
    byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (sel == g[0])),
      .addr(ptr), .wdata(sh), .rdata(rd[g])
    );
  end

  assign rdata    = sel ? rd[1] : rd[0];
  assign ptr_nxt  = (ptr == LAST) ? '0 : ptr + AW'(1);
  assign id_usr   = (sh[7:1] == USR_ID);
  assign id_hit   = (sh[7:1] == REG_ID) || id_usr;
  assign wr_en    = (st == ST_RX) && full && scl_fall && (kind == K_DATA);
  assign tx_load  = scl_fall &&
                    (((st == ST_RX_ACK) && (kind == K_ID) && rw) ||
                     ((st == ST_MACK) && m_ack));
  assign ptr_step = wr_en || tx_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind   <= K_ID;
      cnt    <= '0;
      full   <= 1'b0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      sel    <= 1'b0;
      rw     <= 1'b0;
      m_ack  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= ST_RX;
      kind   <= K_ID;
      cnt    <= '0;
      full   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      if (tx_load) begin
        tx     <= rdata;
        sda_oe <= ~rdata[7];
        cnt    <= '0;
        st     <= ST_TX;
      end
      if (ptr_step) ptr <= ptr_nxt;
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_s};
            cnt  <= cnt + 3'd1;
            full <= (cnt == 3'd7);
          end else if (scl_fall && full) begin
            full <= 1'b0;
            unique case (kind)
              K_ID: begin
                if (id_hit) begin
                  sel    <= id_usr;
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end
              K_ADDR: begin
                ptr    <= (sh > 8'(DEPTH - 1)) ? '0 : sh[AW-1:0];
                sda_oe <= 1'b1;
                st     <= ST_RX_ACK;
              end
              default: begin
                sda_oe <= 1'b1;
                st     <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall && !tx_load) begin
            sda_oe <= 1'b0;
            kind   <= (kind == K_ID) ? K_ADDR : K_DATA;
            cnt    <= '0;
            st     <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
              cnt    <= cnt + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          else if (scl_fall && !m_ack) st <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_dual_slave_chk.sv
module i2c_dual_slave_chk
  import i2c_dual_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int AW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input ctl_st_t       st,
  input logic [AW-1:0] ptr,
  input logic          ptr_step,
  input logic          start_det,
  input logic          stop_det
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr == LAST) |=> (ptr == '0));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr != LAST) |=> (ptr == AW'($past(ptr) + AW'(1))));

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && st == ST_RX));

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE));
endmodule

bind i2c_dual_slave i2c_dual_slave_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .st(st),
  .ptr(ptr), .ptr_step(ptr_step), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/tb_i2c_dual_slave.sv
module tb_i2c_dual_slave;
  localparam int Q = 8;
  localparam logic [6:0] RID = 7'h6F;
  localparam logic [6:0] UID = 7'h57;
  localparam int DEPTH = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_dual_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mdl [2][DEPTH];
  int mptr = 0;
  logic [7:0] exp_q [$];
  string rq_q [$];
  logic [7:0] wq [$];
  logic [7:0] got_byte;
  event got_ev;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; w(Q);
    scl_m = 1'b1; w(2 * Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    b = sda_line; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic wbyte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(logic ack);
    logic [7:0] d;
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      recv_bit(b);
      d = {d[6:0], b};
    end
    send_bit(~ack);
    got_byte = d;
    ->got_ev;
  endtask

  function automatic int sp(logic [6:0] id);
    return (id == UID) ? 1 : 0;
  endfunction

  // write: ID(R/W=0), address, then bytes from wq
  task automatic wr(logic [6:0] id, logic [7:0] addr, string req);
    logic ack;
    bus_start();
    wbyte({id, 1'b0}, ack); chk("R1", 8'(ack), 8'd1);
    wbyte(addr, ack);       chk("R3", 8'(ack), 8'd1);
    mptr = (addr > 8'd47) ? 0 : int'(addr);
    while (wq.size() > 0) begin
      logic [7:0] d;
      d = wq.pop_front();
      wbyte(d, ack); chk(req, 8'(ack), 8'd1);
      mdl[sp(id)][mptr] = d;
      mptr = (mptr == DEPTH - 1) ? 0 : mptr + 1;
    end
    bus_stop();
    chk("R9", 8'(sda_oe), 8'd0);
  endtask

  task automatic read_n(logic [6:0] id, int n, string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mdl[sp(id)][mptr]);
      rq_q.push_back(req);
      mptr = (mptr == DEPTH - 1) ? 0 : mptr + 1;
      rbyte(i < n - 1);
    end
    bus_stop();
  endtask

  task automatic rd_cur(logic [6:0] id, int n, string req);
    logic ack;
    bus_start();
    wbyte({id, 1'b1}, ack); chk("R2", 8'(ack), 8'd1);
    read_n(id, n, req);
  endtask

  task automatic rd_rand(logic [6:0] id, logic [7:0] addr, int n, string req);
    logic ack;
    bus_start();
    wbyte({id, 1'b0}, ack); chk("R5", 8'(ack), 8'd1);
    wbyte(addr, ack);       chk("R5", 8'(ack), 8'd1);
    mptr = (addr > 8'd47) ? 0 : int'(addr);
    bus_start();
    wbyte({id, 1'b1}, ack); chk("R5", 8'(ack), 8'd1);
    read_n(id, n, req);
  endtask

  // monitor: pops the next expected byte for every byte received
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) chk("R6", got_byte, 8'hXX);
      else chk(rq_q.pop_front(), got_byte, exp_q.pop_front());
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog got=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic ack;
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < DEPTH; a++) mdl[s][a] = 8'h00;
    w(5);
    chk("R9", 8'(sda_oe), 8'd0);
    rst_n = 1'b1;
    w(5);
    chk("R9", 8'(sda_oe), 8'd0);

    // R4 R10: current-address read at power-up starts at 00h
    rd_cur(RID, 1, "R4");
    // R3: write three bytes from 01h
    wq = '{8'hA1, 8'hB2, 8'hC3};
    wr(RID, 8'h01, "R3");
    // R7: write wraps 2Fh -> 00h
    wq = '{8'h11, 8'h22, 8'h33};
    wr(RID, 8'h2E, "R7");
    // R5 R7: random read across the wrap
    rd_rand(RID, 8'h2E, 4, "R7");
    // R6: pointer kept after NACK, continues
    rd_cur(RID, 2, "R6");
    // R1: user space is separate
    wq = '{8'h5A, 8'hA5};
    wr(UID, 8'h10, "R3");
    rd_rand(UID, 8'h10, 2, "R1");
    rd_rand(RID, 8'h10, 1, "R1");
    // R12: shared pointer (0x11 now) used by user space
    rd_cur(UID, 1, "R12");

    // R1: foreign identifier NACKed, rest of the transfer ignored
    bus_start();
    wbyte(8'h90, ack); chk("R1", 8'(ack), 8'd0);
    wbyte(8'h01, ack); chk("R1", 8'(ack), 8'd0);
    wbyte(8'hEE, ack); chk("R1", 8'(ack), 8'd0);
    bus_stop();
    rd_rand(RID, 8'h01, 1, "R1");

    // R8: address above 2Fh clamps to 00h
    wq = '{8'h77};
    wr(RID, 8'h80, "R8");
    rd_rand(RID, 8'h35, 1, "R8");

    // R11: STOP right after the address byte keeps the pointer
    wq = '{8'h9C};
    wr(RID, 8'h20, "R3");
    bus_start();
    wbyte({RID, 1'b0}, ack); chk("R11", 8'(ack), 8'd1);
    wbyte(8'h20, ack);       chk("R11", 8'(ack), 8'd1);
    bus_stop();
    mptr = 8'h20;
    chk("R11", 8'(sda_oe), 8'd0);
    rd_cur(RID, 1, "R11");

    w(4 * Q);
    chk("R6", 8'(exp_q.size()), 8'd0);
    finish_run();
  end
endmodule